// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers interrupt request lines that are organised in groups, by default 8 groups of 32 lines each. Software gives every group a priority word through a small register port. The word holds a 2-bit level and a word-aligned handler offset. Each cycle the block picks one winning group among those with a pending line whose level the CPU has not masked. It then presents that group's level and handler offset to the CPU with a valid flag.

The request lines are sampled into per-group pending registers, and arbitration works on those registers. The highest level wins, and among groups at that level the lowest group number wins. The CPU learns only the level and the offset. To identify the source, software reads the cause register of that level, which holds the number of the last group granted there, and then the pending register of that group.

Top module: `intc_top`

## Requirements
- R1: A request at flat index i (i = group*LINES + line) appears, one clock after it is sampled, as bit (i mod LINES) of the pending register of group i/LINES. That register is read at address {2'b01, group}.
- R2: A priority word is written and read at address {2'b00, group}. The level sits in bits [17:16] and the handler offset in bits [13:2]. Every other bit, including offset bits [1:0], reads as zero. All priority words are zero after reset.
- R3: irq_valid is low whenever no group with a pending line has an unmasked level.
- R4: Among eligible groups, the one with the highest level (3 highest, 0 lowest) wins.
- R5: Among eligible groups that share the highest level, the lowest-numbered group wins.
- R6: A group whose level has its bit set in level_mask (1 = masked) takes no part in arbitration.
- R7: While irq_valid is high, irq_level and irq_vector carry the winner's level and offset. While it is low, both are zero. No line number is presented.
- R8: On each clock edge where irq_valid is high, the cause register of the winning level takes the winning group number. The cause registers of the other levels hold. Cause registers reset to zero and are read at address {2'b10, level} in the low bits.
- R9: Writes to the pending or cause address ranges change nothing that can be read back. Reads of unused addresses return zero.
- R10: The outputs are a function of the pending and priority registers and of the current level_mask. A line change therefore reaches irq_valid one clock after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lines | input | NUM_GROUPS*LINES | Flat request lines, group-major |
| level_mask | input | 4 | One mask bit per level, 1 = masked |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | {space[1:0], index[5:0]} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| irq_valid | output | 1 | A request is presented to the CPU |
| irq_level | output | 2 | Level of the winning group |
| irq_vector | output | 14 | Handler offset of the winning group |

## Verification
The hardest case to reach is several groups pending at once with equal levels, combined with a mask that removes the highest level. Only that combination separates the level comparison, the tie-break and the mask from one another. The stimulus first programs a chosen level map and then sets lines in several groups together, stepping the mask through its values. After that it runs a long random phase with sparse lines and random masks. Cause registers are read back at each level between changes, so the tracking of the winning group shows at the register port.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LVL_W      = 2;
  localparam int VEC_W      = 14;
  localparam int NUM_LEVELS = 4;
  localparam int ADDR_W     = 8;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic [VEC_W-1:0] vec;
  } prio_t;

  typedef enum logic [1:0] {
    SP_PRIO  = 2'b00,
    SP_PEND  = 2'b01,
    SP_CAUSE = 2'b10,
    SP_NONE  = 2'b11
  } space_e;
endpackage

// File: rtl/intc_group_slot.sv
module intc_group_slot
  import intc_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines,
  input  logic             wr_en,
  input  logic [31:0]      wdata,
  output logic [LINES-1:0] pend,
  output prio_t            prio,
  output logic             active
);
  logic [LINES-1:0] pend_q, pend_d;
  prio_t            prio_q, prio_d;

  always_comb begin
    pend_d = lines;
    prio_d = prio_q;
    if (wr_en) begin
      prio_d.lvl = wdata[17:16];
      prio_d.vec = {wdata[13:2], 2'b00};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      prio_q <= '0;
    end else begin
      pend_q <= pend_d;
      prio_q <= prio_d;
    end
  end

  assign pend   = pend_q;
  assign prio   = prio_q;
  assign active = |pend_q;

  assert_prio_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (prio.lvl == $past(wdata[17:16])) && (prio.vec == {$past(wdata[13:2]), 2'b00}));
  assert_pend_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pend == $past(lines));
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic [NUM_GROUPS-1:0]            active,
  input  logic [NUM_GROUPS-1:0][LVL_W-1:0] lvl,
  input  logic [NUM_LEVELS-1:0]            level_mask,
  output logic                             valid,
  output logic [GW-1:0]                    win_grp,
  output logic [LVL_W-1:0]                 win_lvl
);
  logic [NUM_GROUPS-1:0] elig;

  always_comb begin
    for (int g = 0; g < NUM_GROUPS; g++)
      elig[g] = active[g] && !level_mask[lvl[g]];
  end

  // Descending scan with >= leaves the lowest index among the highest level.
  always_comb begin
    valid   = 1'b0;
    win_grp = '0;
    win_lvl = '0;
    for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
      if (elig[g] && (!valid || lvl[g] >= win_lvl)) begin
        valid   = 1'b1;
        win_grp = GW'(g);
        win_lvl = lvl[g];
      end
    end
  end

  always_comb begin
    if (valid) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        assert_winner_R4: assert (!(elig[g] && (lvl[g] > win_lvl)));
        assert_tie_R5: assert (!(elig[g] && (lvl[g] == win_lvl) && (GW'(g) < win_grp)));
      end
    end
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int LINES      = 32,
  localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_GROUPS*LINES-1:0] irq_lines,
  input  logic [NUM_LEVELS-1:0]       level_mask,
  input  logic                        reg_wr_en,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  output logic                        irq_valid,
  output logic [LVL_W-1:0]            irq_level,
  output logic [VEC_W-1:0]            irq_vector
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  space_e     space;
  logic [5:0] index;
  assign space = space_e'(reg_addr[7:6]);
  assign index = reg_addr[5:0];

  logic [NUM_GROUPS-1:0]              active;
  logic [NUM_GROUPS-1:0][LVL_W-1:0]   lvl_vec;
  logic [NUM_GROUPS-1:0][LINES-1:0]   pend;
  prio_t                              prio [NUM_GROUPS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_slot
    logic wr_sel;
    assign wr_sel = reg_wr_en && (space == SP_PRIO) && (index == 6'(g));
    intc_group_slot #(.LINES(LINES)) u_slot (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .lines  (irq_lines[g*LINES +: LINES]),
      .wr_en  (wr_sel),
      .wdata  (reg_wdata),
      .pend   (pend[g]),
      .prio   (prio[g]),
      .active (active[g])
    );
    assign lvl_vec[g] = prio[g].lvl;
  end

  logic             arb_valid;
  logic [GW-1:0]    win_grp;
  logic [LVL_W-1:0] win_lvl;

  intc_arbiter #(.NUM_GROUPS(NUM_GROUPS)) u_arb (
    .active     (active),
    .lvl        (lvl_vec),
    .level_mask (level_mask),
    .valid      (arb_valid),
    .win_grp    (win_grp),
    .win_lvl    (win_lvl)
  );

  assign irq_valid  = arb_valid;
  assign irq_level  = arb_valid ? win_lvl : '0;
  assign irq_vector = arb_valid ? prio[win_grp].vec : '0;

  // Cause registers, one per level.
  logic [GW-1:0] cause_q [NUM_LEVELS];
  logic [GW-1:0] cause_d [NUM_LEVELS];

  always_comb begin
    for (int l = 0; l < NUM_LEVELS; l++) begin
      cause_d[l] = cause_q[l];
      if (arb_valid && (win_lvl == LVL_W'(l))) cause_d[l] = win_grp;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      for (int l = 0; l < NUM_LEVELS; l++) cause_q[l] <= '0;
    end else begin
      for (int l = 0; l < NUM_LEVELS; l++) cause_q[l] <= cause_d[l];
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (space)
      SP_PRIO: if (index < 6'(NUM_GROUPS))
        reg_rdata = {14'd0, prio[index[GW-1:0]].lvl, 2'b00, prio[index[GW-1:0]].vec};
      SP_PEND: if (index < 6'(NUM_GROUPS))
        reg_rdata = 32'(pend[index[GW-1:0]]);
      SP_CAUSE: if (index < 6'(NUM_LEVELS))
        reg_rdata = 32'(cause_q[index[1:0]]);
      default: reg_rdata = '0;
    endcase
  end

  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (active == '0) |-> !irq_valid);
  assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_valid |-> !level_mask[irq_level]);
  assert_cause_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_valid |=> cause_q[$past(irq_level)] == $past(win_grp));
  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !irq_valid |-> (irq_level == '0 && irq_vector == '0));
endmodule

// File: tb/intc_top_test.sv
module intc_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 8;
  localparam int NL = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NG*NL-1:0]  irq_lines;
  logic [3:0]        level_mask;
  logic              reg_wr_en;
  logic [7:0]        reg_addr;
  logic [31:0]       reg_wdata;
  logic [31:0]       reg_rdata;
  logic              irq_valid;
  logic [1:0]        irq_level;
  logic [13:0]       irq_vector;

  intc_top #(.NUM_GROUPS(NG), .LINES(NL)) uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .level_mask(level_mask),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_valid(irq_valid), .irq_level(irq_level),
    .irq_vector(irq_vector)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference state
  logic [NL-1:0] m_pend [NG];
  int            m_lvl  [NG];
  int            m_vec  [NG];
  int            m_cause[4];

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic arbitrate(output bit v, output int lv, output int gr);
    v = 0; lv = 0; gr = 0;
    for (int g = 0; g < NG; g++) begin
      if (m_pend[g] != 0 && !level_mask[m_lvl[g]]) begin
        if (!v || m_lvl[g] > lv) begin
          v = 1; lv = m_lvl[g]; gr = g;
        end
      end
    end
  endtask

  function automatic logic [31:0] exp_read(logic [7:0] a);
    int idx = a[5:0];
    case (a[7:6])
      2'b00: return (idx < NG) ? ((32'(m_lvl[idx]) << 16) | 32'(m_vec[idx])) : 32'd0;
      2'b01: return (idx < NG) ? 32'(m_pend[idx]) : 32'd0;
      2'b10: return (idx < 4) ? 32'(m_cause[idx]) : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_edge();
    bit v; int lv, gr;
    arbitrate(v, lv, gr);
    if (v) m_cause[lv] = gr;
    for (int g = 0; g < NG; g++) m_pend[g] = irq_lines[g*NL +: NL];
    if (reg_wr_en && reg_addr[7:6] == 2'b00 && reg_addr[5:0] < NG) begin
      m_lvl[reg_addr[5:0]] = int'(reg_wdata[17:16]);
      m_vec[reg_addr[5:0]] = int'({reg_wdata[13:2], 2'b00});
    end
  endtask

  task automatic compare(string tag);
    bit v; int lv, gr;
    arbitrate(v, lv, gr);
    check(tag, "irq_valid", irq_valid, v);
    check(tag, "irq_level", irq_level, v ? lv : 0);
    check(tag, "irq_vector", irq_vector, v ? m_vec[gr] : 0);
    check(tag, "reg_rdata", reg_rdata, exp_read(reg_addr));
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
    reg_wr_en = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    tick(tag);
  endtask

  task automatic rd(logic [7:0] a, string tag);
    reg_addr = a;
    #1;
    check(tag, "readback", reg_rdata, exp_read(a));
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    for (int g = 0; g < NG; g++) begin m_pend[g] = '0; m_lvl[g] = 0; m_vec[g] = 0; end
    for (int l = 0; l < 4; l++) m_cause[l] = 0;
    rst_n = 0; irq_lines = '0; level_mask = 4'h0;
    reg_wr_en = 0; reg_addr = 8'h00; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // Reset state
    compare("R2 reset");
    for (int g = 0; g < NG; g++) rd(8'(g), "R2 reset prio");
    for (int l = 0; l < 4; l++) rd(8'h80 | 8'(l), "R8 reset cause");

    // R2 layout
    wr(8'h02, 32'hFFFF_FFFF, "R2 write");
    rd(8'h02, "R2 field layout");
    wr(8'h02, 32'h0000_0000, "R2 clear");

    // Program levels: g0=1,g1=2,g2=2,g3=3,g4=0,g5=3,g6=1,g7=0
    begin
      int lvls[NG] = '{1, 2, 2, 3, 0, 3, 1, 0};
      for (int g = 0; g < NG; g++)
        wr(8'(g), (32'(lvls[g]) << 16) | (32'(g + 1) << 4), "R2 program");
    end

    // R1 flat index mapping: index 70 -> group 2 line 6
    irq_lines = '0; irq_lines[70] = 1'b1;
    reg_addr = 8'h42;
    tick("R1 R10 line 70 sampled");
    rd(8'h42, "R1 pending group2");
    check("R1", "pending bit6", reg_rdata[6], 1);
    check("R7", "level of group2", irq_level, 2);

    // R4 higher level wins: group 3 (lvl3) over group 2
    irq_lines[3*NL + 31] = 1'b1;
    tick("R4 level wins");
    check("R4", "vector group3", irq_vector, 14'h40);

    // R5 tie at level 3: groups 3 and 5, lowest wins
    irq_lines[5*NL + 0] = 1'b1;
    tick("R5 tie lowest");
    check("R5", "vector group3 tie", irq_vector, 14'h40);
    irq_lines[3*NL + 31] = 1'b0;
    tick("R5 group5 alone");
    check("R5", "vector group5", irq_vector, 14'h60);

    // R6 mask level 3 -> level 2 group 2 wins
    level_mask = 4'b1000;
    tick("R6 mask lvl3");
    check("R6", "masked level", irq_level, 2);
    level_mask = 4'b1100;
    tick("R6 R3 all masked");
    check("R3", "valid low", irq_valid, 0);
    for (int l = 0; l < 4; l++) rd(8'h80 | 8'(l), "R8 cause readback");

    // R3 nothing pending
    level_mask = 4'b0000;
    irq_lines = '0;
    tick("R10 clear sampled");
    tick("R3 idle");
    check("R3", "idle valid", irq_valid, 0);

    // R9 writes to read-only spaces
    irq_lines[1*NL + 4] = 1'b1;
    tick("R9 setup");
    wr(8'h41, 32'h0000_0000, "R9 write pend");
    wr(8'h80, 32'hFFFF_FFFF, "R9 write cause");
    wr(8'hC3, 32'hFFFF_FFFF, "R9 write unused");
    rd(8'h41, "R9 pending intact");
    rd(8'h80, "R9 cause intact");
    rd(8'hC3, "R9 unused zero");
    rd(8'h3F, "R9 prio out of range");

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      irq_lines = '0;
      for (int k = 0; k < int'($urandom % 4); k++) irq_lines[$urandom % (NG*NL)] = 1'b1;
      level_mask = 4'($urandom);
      reg_addr = 8'($urandom);
      if (reg_addr[7:6] == 2'b00) reg_addr[5:3] = 3'b000;
      if (($urandom % 4) == 0) begin
        reg_wr_en = 1; reg_wdata = $urandom;
      end
      tick("R3 R4 R5 R6 R7 R8 R10 random");
    end

    finish_up();
  end
endmodule